// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block holds the interrupt state of one processor for 256 vectors. Three bitmaps record which vectors are waiting, which are being serviced, and which were raised as level-triggered. Fixed-mode requests arrive as a vector with an edge/level flag. The block keeps a task-priority value written by software. From that value and the highest in-service vector it derives a processor priority. It offers the core the highest waiting vector only when that vector's priority class is above the processor priority.

When the core takes the offered vector, the vector moves from waiting to in-service, and the processor priority rises to match. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered, the block emits a one-cycle broadcast carrying the vector, so that the source can re-arm. A suppression input turns that broadcast off.

The request input is a valid/ready stream that never applies back-pressure: `req_ready` is held high, and every cycle with `req_valid` high is one request. The offered vector is a valid/ready pair. `irq_valid` with `irq_vector` is the offer, and `irq_ack` is the ready. A transfer happens in a cycle where both are high. An acknowledge while `irq_valid` is low is ignored. The broadcast output is a plain pulse with no ready.

Top module: `vpr_resolver`

## Requirements
- R1: After reset no vector is waiting or in service, the task priority is 0, `ppr` reads 0, and `irq_valid`, `eoi_out_valid` and `req_dup` are low.
- R2: An accepted request marks its vector waiting. `irq_vector` shows the numerically highest waiting vector, and `irq_valid` rises in the cycle after the request.
- R3: `irq_valid` is high only when the offered vector, with its low four bits cleared, is strictly greater than `ppr`.
- R4: `ppr` equals the task priority when task-priority bits [7:4] are at least bits [7:4] of the highest in-service vector (taken as 0 when none). Otherwise `ppr` equals that in-service vector with bits [3:0] cleared.
- R5: An accepted acknowledge marks the offered vector in service, clears its waiting bit, and updates `ppr` in the next cycle.
- R6: An end-of-interrupt strobe retires only the highest in-service vector, and `ppr` is recomputed in the next cycle.
- R7: Retiring a level-triggered vector raises `eoi_out_valid` for exactly one cycle, with `eoi_out_vector` equal to that vector. Retiring an edge-triggered vector raises nothing.
- R8: While `eoi_bcast_off` is high, no broadcast is emitted, but the vector is still retired.
- R9: A request for a vector that is already waiting raises `req_dup` for one cycle after the request. A first request does not.
- R10: While `ctl_enable` is low, requests are dropped without trace and `irq_valid` is low.
- R11: Requests for vectors 0 to 15 are ignored.
- R12: An end-of-interrupt strobe with nothing in service changes nothing: `ppr` is unchanged and no broadcast is emitted.
- R13: When a request and an acknowledge arrive in the same cycle, the acknowledge takes the vector offered before the request is applied.
- R14: Every accepted request rewrites its vector's trigger flag. A level request followed by an edge request for the same vector leaves it edge-triggered, so its retirement emits no broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Controller enable; low drops requests and hides offers |
| eoi_bcast_off | input | 1 | Suppress level end-of-interrupt broadcasts |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; request stream never stalls |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_dup | output | 1 | Previous-cycle request found its vector already waiting |
| irq_valid | output | 1 | A deliverable vector is offered |
| irq_vector | output | 8 | Offered vector |
| irq_ack | input | 1 | Core takes the offered vector |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_out_valid | output | 1 | One-cycle level end-of-interrupt broadcast |
| eoi_out_vector | output | 8 | Vector carried by the broadcast |
| ppr | output | 8 | Current processor priority |

## Verification
All state is registered on the rising edge, and `irq_valid`, `irq_vector` and `ppr` are decoded from that state without further registers. A request, an acknowledge, a task-priority write or an end-of-interrupt strobe is therefore visible on those outputs one cycle later. `req_dup` and the broadcast pair are registered alongside the state, so they are also due one cycle after their cause, and they drop again the cycle after that. The bench drives every strobe at the falling edge and holds it over one rising edge. It samples at the following falling edge, then samples again one cycle later to confirm that the pulses have ended.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int VEC_W   = 8;
  localparam int CLASS_W = 4;
  localparam int MIN_VEC = 16;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/vpr_hi_scan.sv
module vpr_hi_scan #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = 8
) (
  input  logic [NUM_VEC-1:0] bits,
  output logic               found,
  output logic [VEC_W-1:0]   idx
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int POS_W     = $clog2(WORD_W);

  logic [NUM_WORDS-1:0] word_any;
  logic [POS_W-1:0]     word_pos [NUM_WORDS];

  // per-word priority encoder
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] slice;
    assign slice       = bits[w*WORD_W +: WORD_W];
    assign word_any[w] = |slice;
    always_comb begin
      word_pos[w] = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (slice[b]) word_pos[w] = POS_W'(b);
      end
    end
  end

  // word select: the highest non-empty word wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_any[w]) begin
        found = 1'b1;
        idx   = VEC_W'((w << POS_W) | int'(word_pos[w]));
      end
    end
  end
endmodule

// File: rtl/vpr_prio_calc.sv
module vpr_prio_calc #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic             enable,
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_found,
  input  logic [VEC_W-1:0] isr_top,
  input  logic             irr_found,
  input  logic [VEC_W-1:0] irr_top,
  output logic [VEC_W-1:0] ppr,
  output logic             deliver
);
  localparam int LO = VEC_W - CLASS_W;

  logic [VEC_W-1:0]   isr_val;
  logic [CLASS_W-1:0] tpr_cls;
  logic [CLASS_W-1:0] isr_cls;
  logic [VEC_W-1:0]   irr_floor;

  assign isr_val   = isr_found ? isr_top : '0;
  assign tpr_cls   = tpr[VEC_W-1:LO];
  assign isr_cls   = isr_val[VEC_W-1:LO];
  assign irr_floor = {irr_top[VEC_W-1:LO], {LO{1'b0}}};

  always_comb begin
    if (tpr_cls >= isr_cls) ppr = tpr;
    else                    ppr = {isr_cls, {LO{1'b0}}};
  end

  assign deliver = enable && irr_found && (irr_floor > ppr);
endmodule

// File: rtl/vpr_bitmap_reg.sv
module vpr_bitmap_reg #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_mask,
  input  logic [NUM_VEC-1:0] clr_mask,
  output logic [NUM_VEC-1:0] q
);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;

  // set wins over clear so a fresh arrival survives a same-cycle retire
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) q[w*WORD_W +: WORD_W] <= '0;
      else q[w*WORD_W +: WORD_W] <= (q[w*WORD_W +: WORD_W] & ~clr_mask[w*WORD_W +: WORD_W])
                                    | set_mask[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/vpr_resolver.sv
module vpr_resolver
  import vpr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_enable,
  input  logic             eoi_bcast_off,
  input  logic             tpr_wr,
  input  logic [VEC_W-1:0] tpr_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_level,
  output logic             req_dup,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             irq_ack,
  input  logic             eoi_wr,
  output logic             eoi_out_valid,
  output logic [VEC_W-1:0] eoi_out_vector,
  output logic [VEC_W-1:0] ppr
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr, tmr_set, tmr_clr;
  logic [NUM_VEC-1:0] req_oh, ack_oh, eoi_oh;
  logic [VEC_W-1:0]   tpr_q;
  logic               irr_found, isr_found;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic               req_ok, ack_fire, eoi_fire;
  logic               dup_q, bcast_q;
  logic [VEC_W-1:0]   bcast_vec_q;

  assign req_ready = 1'b1;

  vpr_hi_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_irr_scan (
    .bits(irr_q), .found(irr_found), .idx(irr_top));

  vpr_hi_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_isr_scan (
    .bits(isr_q), .found(isr_found), .idx(isr_top));

  vpr_prio_calc #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
    .enable(ctl_enable), .tpr(tpr_q),
    .isr_found(isr_found), .isr_top(isr_top),
    .irr_found(irr_found), .irr_top(irr_top),
    .ppr(ppr), .deliver(irq_valid));

  assign irq_vector = irr_top;

  // event qualification, all from pre-update state
  assign req_ok   = req_valid && req_ready && ctl_enable && (req_vector >= VEC_W'(MIN_VEC));
  assign ack_fire = irq_ack && irq_valid;
  assign eoi_fire = eoi_wr && isr_found;

  assign req_oh = NUM_VEC'(1) << req_vector;
  assign ack_oh = NUM_VEC'(1) << irr_top;
  assign eoi_oh = NUM_VEC'(1) << isr_top;

  assign irr_set = req_ok   ? req_oh : '0;
  assign irr_clr = ack_fire ? ack_oh : '0;
  assign isr_set = ack_fire ? ack_oh : '0;
  assign isr_clr = eoi_fire ? eoi_oh : '0;
  assign tmr_set = (req_ok && req_level) ? req_oh : '0;
  assign tmr_clr = ((req_ok && !req_level) ? req_oh : '0) | (eoi_fire ? eoi_oh : '0);

  vpr_bitmap_reg #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr (
    .clk(clk), .rst_n(rst_n), .set_mask(irr_set), .clr_mask(irr_clr), .q(irr_q));

  vpr_bitmap_reg #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_mask(isr_set), .clr_mask(isr_clr), .q(isr_q));

  vpr_bitmap_reg #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .set_mask(tmr_set), .clr_mask(tmr_clr), .q(tmr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q       <= '0;
      dup_q       <= 1'b0;
      bcast_q     <= 1'b0;
      bcast_vec_q <= '0;
    end else begin
      if (tpr_wr) tpr_q <= tpr_wdata;
      dup_q   <= req_ok && irr_q[req_vector] && !(ack_fire && (irr_top == req_vector));
      bcast_q <= eoi_fire && tmr_q[isr_top] && !eoi_bcast_off;
      if (eoi_fire) bcast_vec_q <= isr_top;
    end
  end

  assign req_dup        = dup_q;
  assign eoi_out_valid  = bcast_q;
  assign eoi_out_vector = bcast_vec_q;
endmodule

// File: rtl/vpr_checker.sv
module vpr_checker
  import vpr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_enable,
  input logic             eoi_bcast_off,
  input logic             eoi_wr,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector,
  input logic             irq_ack,
  input logic             eoi_out_valid,
  input logic [VEC_W-1:0] ppr
);
  // R3: an offered vector outranks the processor priority
  a_r3_offer_above_ppr: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ({irq_vector[7:4], 4'h0} > ppr));

  // R10: disabled controller offers nothing
  a_r10_no_offer_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> !irq_valid);

  // R11: reserved low vectors never offered
  a_r11_no_low_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= 8'd16));

  // R5: after an acknowledge the priority reaches the taken class
  a_r5_ack_raises_ppr: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && !eoi_wr) |=> (ppr[7:4] >= $past(irq_vector[7:4])));

  // R7: a broadcast only follows an end-of-interrupt strobe
  a_r7_bcast_after_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_out_valid |-> $past(eoi_wr));

  // R8: suppression blocks the broadcast
  a_r8_bcast_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_out_valid |-> !$past(eoi_bcast_off));
endmodule

bind vpr_resolver vpr_checker u_chk (.*);

// File: tb/sim_vpr_resolver.sv
module sim_vpr_resolver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_enable, eoi_bcast_off, tpr_wr, req_valid, req_level, irq_ack, eoi_wr;
  logic [7:0] tpr_wdata, req_vector;
  logic       req_ready, req_dup, irq_valid, eoi_out_valid;
  logic [7:0] irq_vector, eoi_out_vector, ppr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vpr_resolver u0 (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .eoi_bcast_off(eoi_bcast_off),
    .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector), .req_level(req_level), .req_dup(req_dup),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ack(irq_ack), .eoi_wr(eoi_wr),
    .eoi_out_valid(eoi_out_valid), .eoi_out_vector(eoi_out_vector), .ppr(ppr));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; irq_ack = 1'b0; eoi_wr = 1'b0; tpr_wr = 1'b0;
  endtask

  task automatic do_req(input logic [7:0] v, input logic lvl);
    req_valid = 1'b1; req_vector = v; req_level = lvl;
    step();
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    step();
  endtask

  task automatic do_eoi();
    eoi_wr = 1'b1;
    step();
  endtask

  task automatic set_tpr(input logic [7:0] v);
    tpr_wr = 1'b1; tpr_wdata = v;
    step();
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; ctl_enable = 1'b1; eoi_bcast_off = 1'b0;
    tpr_wr = 1'b0; tpr_wdata = '0; req_valid = 1'b0; req_vector = '0;
    req_level = 1'b0; irq_ack = 1'b0; eoi_wr = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R1 irq_valid", int'(irq_valid), 0);
    chk("R1 ppr", int'(ppr), 0);
    chk("R1 eoi_out_valid", int'(eoi_out_valid), 0);
    chk("R1 req_dup", int'(req_dup), 0);
    chk("R1 req_ready", int'(req_ready), 1);
  endtask

  task automatic t_order();
    apply_reset();
    do_req(8'h45, 1'b0);
    chk("R2 valid after first", int'(irq_valid), 1);
    chk("R2 vector 45", int'(irq_vector), 'h45);
    do_req(8'h80, 1'b0);
    chk("R2 vector 80", int'(irq_vector), 'h80);
    do_req(8'h47, 1'b0);
    chk("R2 highest kept", int'(irq_vector), 'h80);
  endtask

  task automatic t_tpr();
    apply_reset();
    set_tpr(8'h85);
    chk("R4 ppr from tpr", int'(ppr), 'h85);
    do_req(8'h8F, 1'b0);
    chk("R3 same class blocked", int'(irq_valid), 0);
    do_req(8'h90, 1'b0);
    chk("R3 higher class offered", int'(irq_valid), 1);
    chk("R3 vector 90", int'(irq_vector), 'h90);
    do_ack();
    chk("R4 ppr from isr", int'(ppr), 'h90);
    chk("R5 lower class held", int'(irq_valid), 0);
    do_eoi();
    chk("R6 ppr back to tpr", int'(ppr), 'h85);
  endtask

  task automatic t_nest();
    apply_reset();
    do_req(8'h30, 1'b0);
    req_valid = 1'b1; req_vector = 8'h70; req_level = 1'b0; irq_ack = 1'b1;
    step();
    chk("R13 ack took old vector", int'(ppr), 'h30);
    chk("R13 new request offered", int'(irq_valid), 1);
    chk("R13 new vector", int'(irq_vector), 'h70);
    do_ack();
    chk("R5 ppr nested", int'(ppr), 'h70);
    chk("R5 waiting cleared", int'(irq_valid), 0);
    do_eoi();
    chk("R6 highest retired", int'(ppr), 'h30);
    do_eoi();
    chk("R6 all retired", int'(ppr), 0);
  endtask

  task automatic t_level();
    apply_reset();
    do_req(8'h61, 1'b1);
    do_ack();
    do_eoi();
    chk("R7 level pulse", int'(eoi_out_valid), 1);
    chk("R7 pulse vector", int'(eoi_out_vector), 'h61);
    step();
    chk("R7 pulse one cycle", int'(eoi_out_valid), 0);
    do_req(8'h62, 1'b0);
    do_ack();
    do_eoi();
    chk("R7 edge no pulse", int'(eoi_out_valid), 0);
  endtask

  task automatic t_direct();
    apply_reset();
    eoi_bcast_off = 1'b1;
    do_req(8'h63, 1'b1);
    do_ack();
    chk("R8 ppr in service", int'(ppr), 'h60);
    do_eoi();
    chk("R8 suppressed", int'(eoi_out_valid), 0);
    chk("R8 still retired", int'(ppr), 0);
    eoi_bcast_off = 1'b0;
  endtask

  task automatic t_dup();
    apply_reset();
    do_req(8'h50, 1'b0);
    chk("R9 first not dup", int'(req_dup), 0);
    do_req(8'h50, 1'b0);
    chk("R9 dup flagged", int'(req_dup), 1);
    step();
    chk("R9 dup one cycle", int'(req_dup), 0);
    do_req(8'h60, 1'b1);
    do_req(8'h60, 1'b0);
    chk("R14 dup on rewrite", int'(req_dup), 1);
    do_ack();
    chk("R14 taken 60", int'(ppr), 'h60);
    do_eoi();
    chk("R14 edge after rewrite", int'(eoi_out_valid), 0);
  endtask

  task automatic t_disable();
    apply_reset();
    ctl_enable = 1'b0;
    do_req(8'h40, 1'b0);
    chk("R10 no offer while off", int'(irq_valid), 0);
    ctl_enable = 1'b1;
    step();
    chk("R10 request dropped", int'(irq_valid), 0);
    do_req(8'h40, 1'b0);
    chk("R10 offer when on", int'(irq_valid), 1);
    ctl_enable = 1'b0;
    step();
    chk("R10 offer hidden", int'(irq_valid), 0);
    ctl_enable = 1'b1;
  endtask

  task automatic t_low();
    apply_reset();
    do_req(8'h0F, 1'b0);
    chk("R11 vector 0F ignored", int'(irq_valid), 0);
    do_req(8'h10, 1'b0);
    chk("R11 vector 10 taken", int'(irq_valid), 1);
    chk("R11 vector value", int'(irq_vector), 'h10);
  endtask

  task automatic t_eoi_empty();
    apply_reset();
    set_tpr(8'h20);
    do_eoi();
    chk("R12 ppr unchanged", int'(ppr), 'h20);
    chk("R12 no pulse", int'(eoi_out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_tpr();
    t_nest();
    t_level();
    t_direct();
    t_dup();
    t_disable();
    t_low();
    t_eoi_empty();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule